// File: doc/BRIEF.md
# Shared-Bus Register Transfer Unit

This block keeps four 8-bit source registers and two 8-bit destination registers that talk over one internal data bus. A 2-bit select code is turned into four active-low enables, with exactly one of them low. The source whose enable is low places its value on the bus. Two independent load strobes copy the bus into the first destination, the second destination, or both, on the rising clock edge.

Each source register has its own parallel data input and write strobe, so its contents can be preset before a transfer. There are no internal tri-states. The bus is an AND-OR selector driven by the decoded enables. The decoded enables and the bus value are brought out as ports so they can be observed.

Top module: `xfer_unit`

## Requirements
- R1: While `rst` is high at a rising edge, all six registers become zero. This takes priority over any write or load strobe in the same cycle, so afterwards `g_q`, `h_q` and `bus_val` read 0.
- R2: When `src_wr[i]` is high at a rising edge, source `i` takes `src_din[i*8 +: 8]`. Source index 0 is A, 1 is B, 2 is C and 3 is D. A source whose strobe is low keeps its value.
- R3: `src_en_n` has exactly one bit low, and that bit is bit `sel`: code 0 gives 4'b1110, 1 gives 4'b1101, 2 gives 4'b1011 and 3 gives 4'b0111.
- R4: In the same cycle, `bus_val` equals the source whose enable bit is low: A for code 0, B for 1, C for 2 and D for 3.
- R5: When `ld_g` is high at a rising edge, `g_q` takes the bus value from before that edge.
- R6: When `ld_h` is high at a rising edge, `h_q` takes the bus value from before that edge.
- R7: When `ld_g` and `ld_h` are both high, both destinations take the same bus value on the same edge.
- R8: A destination whose load strobe is low keeps its contents, even when the sources or the select change.
- R9: When a source is written and loaded into a destination on the same edge, the destination receives the source's old value. The bus shows the new value after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| src_wr | input | 4 | Per-source write strobes, bit 0 = A |
| src_din | input | 32 | Packed source data, A in bits 7:0 |
| sel | input | 2 | Bus source select code |
| ld_g | input | 1 | Load strobe for destination G |
| ld_h | input | 1 | Load strobe for destination H |
| src_en_n | output | 4 | Decoded active-low source enables |
| bus_val | output | 8 | Current bus value |
| g_q | output | 8 | Destination G contents |
| h_q | output | 8 | Destination H contents |

## Verification
Two functions can land on the same edge: writing a source register, and loading a destination from the bus while that same source is selected. The bench sets `sel` to A, then raises the A write strobe and `ld_g` together. It expects `g_q` to hold the old A value while `bus_val` already shows the new one. A second case pulses reset together with writes and loads, and expects every register to read zero.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int DEF_DW   = 8;
  localparam int DEF_NSRC = 4;

  // Active-low one-hot pattern: only bit idx is low.
  function automatic logic [DEF_NSRC-1:0] low_hot(input int unsigned idx);
    logic [DEF_NSRC-1:0] v;
    for (int k = 0; k < DEF_NSRC; k++) v[k] = (k != idx);
    return v;
  endfunction
endpackage

// File: rtl/xfer_src_bank.sv
module xfer_src_bank #(
  parameter int DW   = 8,
  parameter int NSRC = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSRC-1:0]      wr,
  input  logic [NSRC*DW-1:0]   din,
  output logic [NSRC*DW-1:0]   q
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [DW-1:0] r;
    always_ff @(posedge clk) begin
      if (rst)        r <= '0;
      else if (wr[i]) r <= din[i*DW +: DW];
    end
    assign q[i*DW +: DW] = r;
  end
endmodule

// File: rtl/xfer_sel_dec.sv
module xfer_sel_dec #(
  parameter int NSRC = 4,
  localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [SELW-1:0] sel,
  output logic [NSRC-1:0] en_n
);
  for (genvar i = 0; i < NSRC; i++) begin : g_dec
    assign en_n[i] = (sel != SELW'(i));
  end
endmodule

// File: rtl/xfer_bus_mux.sv
module xfer_bus_mux #(
  parameter int DW   = 8,
  parameter int NSRC = 4
) (
  input  logic [NSRC-1:0]    en_n,
  input  logic [NSRC*DW-1:0] src,
  output logic [DW-1:0]      bus
);
  // AND-OR selection: each source is gated by its own enable.
  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++)
      bus = bus | (src[i*DW +: DW] & {DW{~en_n[i]}});
  end
endmodule

// File: rtl/xfer_dst_bank.sv
module xfer_dst_bank #(
  parameter int DW   = 8,
  parameter int NDST = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NDST-1:0]    ld,
  input  logic [DW-1:0]      bus,
  output logic [NDST*DW-1:0] q
);
  for (genvar j = 0; j < NDST; j++) begin : g_dst
    logic [DW-1:0] r;
    always_ff @(posedge clk) begin
      if (rst)        r <= '0;
      else if (ld[j]) r <= bus;
    end
    assign q[j*DW +: DW] = r;
  end
endmodule

// File: rtl/xfer_unit.sv
module xfer_unit
  import xfer_pkg::*;
#(
  parameter int DW   = DEF_DW,
  parameter int NSRC = DEF_NSRC,
  localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC-1:0]    src_wr,
  input  logic [NSRC*DW-1:0] src_din,
  input  logic [SELW-1:0]    sel,
  input  logic               ld_g,
  input  logic               ld_h,
  output logic [NSRC-1:0]    src_en_n,
  output logic [DW-1:0]      bus_val,
  output logic [DW-1:0]      g_q,
  output logic [DW-1:0]      h_q
);
  logic [NSRC*DW-1:0] src_q;
  logic [2*DW-1:0]    dst_q;

  xfer_src_bank #(.DW(DW), .NSRC(NSRC)) u_src (
    .clk(clk), .rst(rst), .wr(src_wr), .din(src_din), .q(src_q)
  );

  xfer_sel_dec #(.NSRC(NSRC)) u_dec (
    .sel(sel), .en_n(src_en_n)
  );

  xfer_bus_mux #(.DW(DW), .NSRC(NSRC)) u_mux (
    .en_n(src_en_n), .src(src_q), .bus(bus_val)
  );

  xfer_dst_bank #(.DW(DW), .NDST(2)) u_dst (
    .clk(clk), .rst(rst), .ld({ld_h, ld_g}), .bus(bus_val), .q(dst_q)
  );

  assign g_q = dst_q[0 +: DW];
  assign h_q = dst_q[DW +: DW];
endmodule

// File: rtl/xfer_unit_chk.sv
module xfer_unit_chk #(
  parameter int DW   = 8,
  parameter int NSRC = 4,
  localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic [SELW-1:0] sel,
  input logic            ld_g,
  input logic            ld_h,
  input logic [NSRC-1:0] src_en_n,
  input logic [DW-1:0]   bus_val,
  input logic [DW-1:0]   g_q,
  input logic [DW-1:0]   h_q
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (g_q == '0 && h_q == '0));

  p_one_low_r3: assert property (@(posedge clk) disable iff (rst)
    $countones(~src_en_n) == 1);

  p_sel_low_r3: assert property (@(posedge clk) disable iff (rst)
    src_en_n[sel] == 1'b0);

  p_load_g_r5: assert property (@(posedge clk) disable iff (rst)
    ld_g |=> g_q == $past(bus_val));

  p_load_h_r6: assert property (@(posedge clk) disable iff (rst)
    ld_h |=> h_q == $past(bus_val));

  p_both_r7: assert property (@(posedge clk) disable iff (rst)
    (ld_g && ld_h) |=> g_q == h_q);

  p_hold_g_r8: assert property (@(posedge clk) disable iff (rst)
    !ld_g |=> $stable(g_q));

  p_hold_h_r8: assert property (@(posedge clk) disable iff (rst)
    !ld_h |=> $stable(h_q));
endmodule

bind xfer_unit xfer_unit_chk #(.DW(DW), .NSRC(NSRC)) u_chk (
  .clk(clk), .rst(rst), .sel(sel), .ld_g(ld_g), .ld_h(ld_h),
  .src_en_n(src_en_n), .bus_val(bus_val), .g_q(g_q), .h_q(h_q)
);

// File: tb/tb_xfer_unit.sv
module tb_xfer_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  src_wr = '0;
  logic [31:0] src_din = '0;
  logic [1:0]  sel = '0;
  logic        ld_g = 1'b0, ld_h = 1'b0;
  logic [3:0]  src_en_n;
  logic [7:0]  bus_val, g_q, h_q;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xfer_unit dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    src_wr = '0; ld_g = 0; ld_h = 0; rst = 0;
  endtask

  task automatic write_all(input logic [7:0] a, b, c, d);
    src_din = {d, c, b, a}; src_wr = 4'hF; step(); idle();
  endtask

  task automatic t_reset();
    rst = 1; step(); step(); idle();
    chk("R1 g after reset", g_q, 0);
    chk("R1 h after reset", h_q, 0);
    chk("R1 bus after reset", bus_val, 0);
  endtask

  task automatic t_decode();
    for (int s = 0; s < 4; s++) begin
      sel = s[1:0]; #1;
      chk("R3 enables", src_en_n, ~(32'(1) << s) & 32'hF);
    end
  endtask

  task automatic t_bus();
    write_all(8'h11, 8'h22, 8'h33, 8'h44);
    for (int s = 0; s < 4; s++) begin
      sel = s[1:0]; #1;
      chk("R4 bus per select", bus_val, 32'(8'h11 * (s + 1)));
    end
  endtask

  task automatic t_single_write();
    src_din = {8'hDD, 8'hCC, 8'hB5, 8'hAA}; src_wr = 4'b0010; step(); idle();
    sel = 1; #1; chk("R2 B written", bus_val, 8'hB5);
    sel = 0; #1; chk("R2 A kept", bus_val, 8'h11);
    sel = 3; #1; chk("R2 D kept", bus_val, 8'h44);
  endtask

  task automatic t_load_g();
    sel = 2; ld_g = 1; step(); idle();
    chk("R5 g loaded from C", g_q, 8'h33);
    chk("R8 h kept", h_q, 0);
  endtask

  task automatic t_load_h();
    sel = 1; ld_h = 1; step(); idle();
    chk("R6 h loaded from B", h_q, 8'hB5);
    chk("R8 g kept", g_q, 8'h33);
  endtask

  task automatic t_both();
    sel = 3; ld_g = 1; ld_h = 1; step(); idle();
    chk("R7 g from D", g_q, 8'h44);
    chk("R7 h from D", h_q, 8'h44);
  endtask

  task automatic t_hold();
    write_all(8'h5A, 8'hA5, 8'h0F, 8'hF0);
    sel = 0; step(); sel = 2; step();
    chk("R8 g holds", g_q, 8'h44);
    chk("R8 h holds", h_q, 8'h44);
  endtask

  task automatic t_collision();
    sel = 0; src_din = {24'h0, 8'hE7}; src_wr = 4'b0001; ld_g = 1; step(); idle();
    chk("R9 g gets old A", g_q, 8'h5A);
    chk("R9 bus shows new A", bus_val, 8'hE7);
    ld_h = 1; step(); idle();
    chk("R9 h gets new A later", h_q, 8'hE7);
  endtask

  task automatic t_reset_prio();
    rst = 1; src_wr = 4'hF; src_din = 32'hFFFF_FFFF; ld_g = 1; ld_h = 1; step(); idle();
    chk("R1 g zero over load", g_q, 0);
    chk("R1 h zero over load", h_q, 0);
    for (int s = 0; s < 4; s++) begin
      sel = s[1:0]; #1; chk("R1 source zero over write", bus_val, 0);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_decode();
    t_bus();
    t_single_write();
    t_load_g();
    t_load_h();
    t_both();
    t_hold();
    t_collision();
    t_reset_prio();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule